// File: doc/BRIEF.md
# Memory Select and Activity Decoder

This block sits between an 8-bit processor's active-low memory bus and two memories: a read-only program region and a writable data region. From the memory-request strobe and address bit 12 it derives one active-low chip enable per region, so that at most one memory is ever selected and only during a memory request. Bit 12 low picks the read-only region (0x0000–0x0FFF) and bit 12 high picks the writable region (0x1000–0x1FFF). Bits 15:13 play no part, so the map repeats every 8 KB.

The processor's read and write strobes go straight to both memories. A write aimed at the read-only region therefore finds no enabled writable memory and changes nothing. In particular it does not alias into the writable region. Two activity flags come out alongside the enables. The read flag marks any memory read. The write flag marks only writes that actually land in the writable memory.

A small read-only pattern memory and a writable memory, both indexed by address bits 11:0, are included so that the block is self-contained. Read data is registered in the manner of a block RAM and appears one clock after the request, together with a valid flag.

Top module: `memsel_top`

## Requirements
- R1: While `mreq_n` is high, `rom_ce_n` and `ram_ce_n` are both high.
- R2: While `mreq_n` is low, address bit 12 low drives `rom_ce_n` low, and bit 12 high drives `ram_ce_n` low. Bits 15:13 are ignored, and storage is indexed by bits 11:0.
- R3: `rom_ce_n` and `ram_ce_n` are never low at the same time.
- R4: The writable memory stores `wdata` at the rising clock edge when `ram_ce_n` is low, `wr_n` is low and `rd_n` is high. A write with bit 12 low changes no stored byte, including the writable byte at the same 12-bit offset.
- R5: `rd_act` is high exactly when `mreq_n` and `rd_n` are both low, whichever region is addressed.
- R6: `wr_act` is high exactly when `ram_ce_n` is low, `wr_n` is low and `rd_n` is high. A write with bit 12 low leaves it low.
- R7: `rd_act` and `wr_act` are never high together. A cycle with both strobes low counts as a read only, and no byte is written.
- R8: One clock after a cycle with `mreq_n` and `rd_n` low, `rdata_vld` is high and `rdata` holds the addressed byte. For the read-only region this byte is offset[7:0] XOR offset[11:4]. For the writable region it is the value held before that edge. After any other cycle `rdata_vld` is low and `rdata` is zero.
- R9: While `rst` is high, and on the first clock after it falls, `rdata_vld` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Write data |
| rom_ce_n | output | 1 | Read-only region chip enable, active low |
| ram_ce_n | output | 1 | Writable region chip enable, active low |
| rd_act | output | 1 | Memory read activity flag |
| wr_act | output | 1 | Effective writable-memory write flag |
| rdata | output | 8 | Registered read data |
| rdata_vld | output | 1 | Read data valid, one clock after a read |

## Verification
The two functions that can meet in one cycle are the read path and the write path. They collide when the bench drives both strobes low together with a memory request. The bench walks all sixteen combinations of request, read, write and bit 12. It judges such cycles on three things: only `rd_act` rises, the read data that follows is valid, and a later read of the same writable offset shows the byte unchanged. Writes into the read-only region are also followed by reads of the same offset in the writable region, which shows that no alias write took place.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  typedef enum logic {REG_ROM = 1'b0, REG_RAM = 1'b1} region_e;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_MEM_AW = 12;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/memsel_decode.sv
module memsel_decode
  import memsel_pkg::*;
(
  input  logic    mreq_n,
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    sel,
  output region_e region,
  output logic    rom_ce_n,
  output logic    ram_ce_n,
  output logic    rd_act,
  output logic    wr_act,
  output logic    ram_we
);
  logic req;

  always_comb begin
    req      = ~mreq_n;
    region   = sel ? REG_RAM : REG_ROM;
    rom_ce_n = ~(req && region == REG_ROM);
    ram_ce_n = ~(req && region == REG_RAM);
    rd_act   = req & ~rd_n;
    // a cycle with both strobes low is a read: the write is suppressed
    wr_act   = ~ram_ce_n & ~wr_n & rd_n;
    ram_we   = wr_act;
  end
endmodule

// File: rtl/memsel_rom.sv
module memsel_rom #(
  parameter int unsigned MEM_AW = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned SHIFT = MEM_AW - DATA_W;

  // computed content: low byte of the offset folded with its upper bits
  always_ff @(posedge clk) begin
    rdata <= DATA_W'(addr) ^ DATA_W'(addr >> SHIFT);
  end
endmodule

// File: rtl/memsel_ram.sv
module memsel_ram #(
  parameter int unsigned MEM_AW = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/memsel_top.sv
module memsel_top
  import memsel_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned MEM_AW = DEF_MEM_AW,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rom_ce_n,
  output logic              ram_ce_n,
  output logic              rd_act,
  output logic              wr_act,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  localparam int unsigned SEL_BIT = MEM_AW;

  region_e           region, src_q;
  logic              ram_we;
  logic              vld_q;
  logic [DATA_W-1:0] rom_q, ram_q;
  logic [MEM_AW-1:0] offset;
  logic              unused_hi;

  assign offset    = addr[MEM_AW-1:0];
  assign unused_hi = ^addr[ADDR_W-1:SEL_BIT+1];

  memsel_decode u_dec (
    .mreq_n  (mreq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sel     (addr[SEL_BIT]),
    .region  (region),
    .rom_ce_n(rom_ce_n),
    .ram_ce_n(ram_ce_n),
    .rd_act  (rd_act),
    .wr_act  (wr_act),
    .ram_we  (ram_we)
  );

  memsel_rom #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_rom (
    .clk  (clk),
    .addr (offset),
    .rdata(rom_q)
  );

  memsel_ram #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (offset),
    .wdata(wdata),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      src_q <= REG_ROM;
    end else begin
      vld_q <= rd_act;
      src_q <= region;
    end
  end

  assign rdata_vld = vld_q;
  assign rdata     = !vld_q ? '0 : (src_q == REG_RAM ? ram_q : rom_q);
endmodule

// File: rtl/memsel_chk.sv
module memsel_chk (
  input logic clk,
  input logic rst,
  input logic mreq_n,
  input logic rd_n,
  input logic wr_n,
  input logic sel,
  input logic rom_ce_n,
  input logic ram_ce_n,
  input logic rd_act,
  input logic wr_act,
  input logic rdata_vld
);
  a_r1_idle_no_enable: assert property (@(posedge clk) disable iff (rst)
    mreq_n |-> (rom_ce_n && ram_ce_n));

  a_r2_ram_region: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && sel) |-> !ram_ce_n);

  a_r2_rom_region: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !sel) |-> !rom_ce_n);

  a_r3_single_enable: assert property (@(posedge clk) disable iff (rst)
    $countones({~rom_ce_n, ~ram_ce_n}) <= 1);

  a_r4_rom_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !wr_n && !sel) |-> (ram_ce_n && !wr_act));

  a_r5_read_flag: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rd_n) |-> rd_act);

  a_r6_write_flag_real: assert property (@(posedge clk) disable iff (rst)
    wr_act |-> (!ram_ce_n && !wr_n));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_act && wr_act));

  a_r8_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rdata_vld |-> $past(!mreq_n && !rd_n));
endmodule

bind memsel_top memsel_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mreq_n   (mreq_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .sel      (addr[SEL_BIT]),
  .rom_ce_n (rom_ce_n),
  .ram_ce_n (ram_ce_n),
  .rd_act   (rd_act),
  .wr_act   (wr_act),
  .rdata_vld(rdata_vld)
);

// File: tb/tb_memsel_top.sv
module tb_memsel_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rom_ce_n, ram_ce_n, rd_act, wr_act, rdata_vld;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit       vld;
    bit       care;
    bit [7:0] data;
    string    tag;
  } exp_t;

  exp_t     sb[$];
  bit [7:0] ram_m [int];

  always #2 clk = ~clk;

  memsel_top dut (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n),
    .rd_act(rd_act), .wr_act(wr_act), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] rom_byte(input bit [11:0] a);
    return a[7:0] ^ a[11:4];
  endfunction

  // driver: one bus cycle, combinational checks, expected read item queued
  task automatic drive(input bit m, input bit r, input bit w,
                       input bit [15:0] a, input bit [7:0] d);
    bit   ram_sel, e_rom, e_ram, e_rd, e_wr;
    exp_t it;
    @(negedge clk);
    mreq_n = m; rd_n = r; wr_n = w; addr = a; wdata = d;
    #1;
    ram_sel = a[12];
    e_rom = !(!m && !ram_sel);
    e_ram = !(!m && ram_sel);
    e_rd  = !m && !r;
    e_wr  = !m && ram_sel && !w && r;
    check(m ? "R1 rom_ce_n" : "R2 rom_ce_n", rom_ce_n, e_rom);
    check(m ? "R1 ram_ce_n" : "R2 ram_ce_n", ram_ce_n, e_ram);
    check("R3 single enable", {31'd0, rom_ce_n | ram_ce_n}, 1);
    check("R5 rd_act", rd_act, e_rd);
    check((!r && !w) ? "R7 wr_act" : "R6 wr_act", wr_act, e_wr);
    it.vld  = e_rd;
    it.care = 1'b1;
    it.data = 8'h00;
    it.tag  = "R8 read data";
    if (e_rd) begin
      if (!ram_sel) it.data = rom_byte(a[11:0]);
      else if (ram_m.exists(int'(a[11:0]))) it.data = ram_m[int'(a[11:0])];
      else it.care = 1'b0;
      if (ram_sel) it.tag = "R4 ram content";
    end
    sb.push_back(it);
    if (e_wr) ram_m[int'(a[11:0])] = d;
  endtask

  // monitor: compare registered read data one clock after the request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check("R8 rdata_vld", rdata_vld, it.vld);
        if (it.care) check(it.tag, rdata, it.data);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with a read request present: valid must stay low (R9)
    mreq_n = 1'b0; rd_n = 1'b0; addr = 16'h0042;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 vld in reset", rdata_vld, 0);
    check("R9 rdata in reset", rdata, 0);
    rst = 1'b0; mreq_n = 1'b1; rd_n = 1'b1;
    @(posedge clk); #1;
    check("R9 vld after reset", rdata_vld, 0);

    // preload writable region
    for (int k = 0; k < 8; k++) drive(0, 1, 0, 16'h1000 + 16'(k * 16'h111), 8'hA0 + 8'(k));
    drive(0, 1, 0, 16'h1123, 8'h5C);
    // read back writable and read-only regions
    for (int k = 0; k < 8; k++) drive(0, 0, 1, 16'h1000 + 16'(k * 16'h111), 8'h00);
    for (int k = 0; k < 6; k++) drive(0, 0, 1, 16'h0000 + 16'(k * 16'h2D7), 8'h00);

    // R4: write into read-only space must not alias into the writable byte
    drive(0, 1, 0, 16'h0123, 8'hEE);
    drive(0, 0, 1, 16'h1123, 8'h00);
    drive(0, 0, 1, 16'h0123, 8'h00);

    // R2: upper bits ignored, mirror every 8 KB
    drive(0, 1, 0, 16'hF456, 8'h3B);
    drive(0, 0, 1, 16'h1456, 8'h00);
    drive(0, 0, 1, 16'hA010, 8'h00);

    // R7: both strobes low on the writable region: read only, no write
    drive(0, 0, 0, 16'h1456, 8'h99);
    drive(0, 0, 1, 16'h1456, 8'h00);

    // every combination of request, read, write and bit 12
    for (int c = 0; c < 16; c++) begin
      bit [15:0] a;
      a = {3'b000, c[0], 12'h2A0 + 12'(c)};
      drive(c[3], c[2], c[1], a, 8'h40 + 8'(c));
    end
    for (int c = 0; c < 16; c++) begin
      drive(0, 0, 1, {3'b000, c[0], 12'h2A0 + 12'(c)}, 8'h00);
    end

    drive(1, 1, 1, 16'h0000, 8'h00);
    drive(1, 1, 1, 16'h0000, 8'h00);
    repeat (3) @(posedge clk);
    #1;
    check("R8 queue drained", sb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule